// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim/Complete

This block collects level-sensitive interrupt requests from a parameterised set of sources and steers them to a small number of targets (contexts), each of which owns one interrupt output line. Software programs a 3-bit priority for every source, a per-context enable bitmap and a per-context threshold over a 32-bit register bus. A context's line rises whenever at least one source it has enabled is pending with a priority above its threshold.

A handler services an interrupt in two steps. It reads the context's claim register, which returns the winning source number and takes that source out of the pending set. It then writes the same number back to signal completion. Between those two steps the source's request gate is closed, so a held-high input cannot retrigger. Source number 0 is reserved: it never requests, and a claim that returns 0 means nothing is waiting.

Top module: `irqc_top`

## Requirements
- R1: After reset every priority, enable bit and threshold reads as 0, no request is pending, every context line is low and `bus_rvalid` is low.
- R2: The priority of source n is a word at byte address 4*n whose bits [2:0] hold the level (0 to 7), with upper bits reading 0. The word at address 0 (source 0) always reads 0 and ignores writes.
- R3: The enable bits for context c start at 0x2000 + c*0x80. Source n is bit n%32 of word n/32, bit 0 of word 0 always reads 0, and each context's bitmap is independent of the others.
- R4: The threshold of context c lives at 0x200000 + c*0x1000 in bits [2:0], and its claim/complete register lives 4 bytes above it. Each context's threshold and claim act only on that context.
- R5: The line of context c is high exactly when some source is pending, enabled for c, and has a priority strictly greater than c's threshold. A priority-0 source never raises a line.
- R6: A claim read returns the number of the eligible source with the highest priority; among equal priorities the lowest number wins. It returns 0 when no source is eligible.
- R7: A claim clears the returned source's pending state and closes its gate. While the gate is closed, the source's input level is ignored.
- R8: Writing a source number to a context's claim/complete address reopens that source's gate, but only if that source is currently claimed and enabled for that context. Any other completion write has no effect.
- R9: A pending request stays pending after its input drops, until it is claimed.
- R10: Writes to unmapped addresses change nothing and reads from them return 0. This includes enable words beyond the source count, contexts beyond the context count, and offsets other than +0 and +4 in a context block.
- R11: Read data and `bus_rvalid` appear in the cycle after a read request, and `bus_rvalid` stays low in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | NUM_SRC | Request levels; bit k is source k+1 |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_rdata | output | 32 | Read data |
| ctx_irq | output | NUM_CTX | Interrupt line of each context |

## Verification
The bench builds the block with seven sources and two contexts. This keeps a single enable word and makes it possible to visit every priority/threshold pair on one source, and to drain every source in model-predicted claim order under several arithmetic priority patterns. Two contexts are enough to show that thresholds, enables and completions cannot leak across context blocks. Seven sources leave the second enable word unmapped, which brings the unmapped-access rules within reach.

// File: rtl/irqc_pkg.sv
// Package: fixed memory map and decode types shared by the interrupt router.
// Assumes a byte-addressed bus; strides are powers of two.
package irqc_pkg;
    localparam logic [31:0] EN_BASE      = 32'h0000_2000;
    localparam int          EN_STRIDE_SH = 7;   // 0x80 bytes per context
    localparam logic [31:0] CTX_BASE     = 32'h0020_0000;
    localparam int          CTX_STRIDE_SH = 12; // 0x1000 bytes per context

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        region_e     kind;
        logic [7:0]  ctx;
        logic [15:0] idx;
    } decode_t;
endpackage

// File: rtl/irqc_gateway.sv
// Module: request gate for one source. It latches a level request as pending,
// converts a claim into the in-flight state and reopens on completion.
// Assumes claim is only raised while the source is pending.
module irqc_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic claim,
    input  logic complete,
    output logic pending,
    output logic inflight
);
    // Gate state: claim dominates, then completion, then a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            inflight <= 1'b0;
        end else if (claim) begin
            pending  <= 1'b0;
            inflight <= 1'b1;
        end else if (complete && inflight) begin
            inflight <= 1'b0;
        end else if (level && !inflight) begin
            pending  <= 1'b1;
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Module: per-context winner selection. It picks the eligible source whose
// priority is above the threshold and highest; a tie keeps the lower number.
// Assumes bit 0 of elig is never set.
module irqc_arbiter #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC:0]              elig,
    input  logic [NUM_SRC:0][PRIO_W-1:0]  prio,
    input  logic [PRIO_W-1:0]             thresh,
    output logic [ID_W-1:0]               best_id
);
    logic [PRIO_W-1:0] best_p;

    // Linear scan: the threshold seeds the running best, so a win needs a strictly greater level.
    always_comb begin
        best_p  = thresh;
        best_id = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (elig[s] && (prio[s] > best_p)) begin
                best_p  = prio[s];
                best_id = ID_W'(s);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
// Module: interrupt router top. It decodes the register map, holds priority,
// enable and threshold state, instantiates one gate per source and one
// arbiter per context, and runs the claim/complete handshake.
// Assumes one bus access per cycle; read data follows one cycle later.
module irqc_top #(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_level,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_rvalid,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CTX-1:0]   ctx_irq
);
    import irqc_pkg::*;

    localparam int ID_W     = $clog2(NUM_SRC + 1);
    localparam int EN_WORDS = (NUM_SRC + 32) / 32;

    logic [NUM_SRC:0][PRIO_W-1:0]  prio_q;
    logic [NUM_CTX-1:0][NUM_SRC:0] en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [NUM_CTX-1:0][ID_W-1:0]  best_id;
    logic [NUM_SRC:0]              level_v;
    logic [NUM_SRC:0]              pend;
    logic [NUM_SRC:0]              infl;
    logic [NUM_SRC:0]              claim_vec;
    logic [NUM_SRC:0]              cmpl_vec;
    logic [NUM_SRC:0]              en_sel;
    logic [ID_W-1:0]               claim_id;
    logic                          claim_go;
    logic                          cmpl_go;
    logic [31:0]                   rd_val;
    logic [31:0]                   a32;
    logic [31:0]                   off;
    decode_t                       dec;

    assign level_v = {src_level, 1'b0};

    // Address decode into region, context and word index.
    always_comb begin
        a32      = 32'(bus_addr);
        off      = '0;
        dec.kind = RG_NONE;
        dec.ctx  = '0;
        dec.idx  = '0;
        if (a32 < 32'((NUM_SRC + 1) * 4)) begin
            dec.kind = RG_PRIO;
            dec.idx  = a32[17:2];
        end else if (a32 >= EN_BASE && a32 < EN_BASE + 32'(NUM_CTX << EN_STRIDE_SH)) begin
            off = a32 - EN_BASE;
            if ({27'd0, off[6:2]} < 32'(EN_WORDS)) begin
                dec.kind = RG_EN;
                dec.ctx  = off[14:7];
                dec.idx  = {11'd0, off[6:2]};
            end
        end else if (a32 >= CTX_BASE && a32 < CTX_BASE + 32'(NUM_CTX << CTX_STRIDE_SH)) begin
            off     = a32 - CTX_BASE;
            dec.ctx = off[19:12];
            if (off[11:2] == 10'd0) dec.kind = RG_THR;
            else if (off[11:2] == 10'd1) dec.kind = RG_CLAIM;
        end
    end

    // Configuration registers: priorities, enable bitmaps, thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (bus_req && bus_we) begin
            for (int s = 1; s <= NUM_SRC; s++) begin
                if (dec.kind == RG_PRIO && dec.idx == 16'(s))
                    prio_q[s] <= bus_wdata[PRIO_W-1:0];
            end
            for (int c = 0; c < NUM_CTX; c++) begin
                if (dec.ctx == 8'(c)) begin
                    if (dec.kind == RG_THR)
                        thr_q[c] <= bus_wdata[PRIO_W-1:0];
                    for (int s = 1; s <= NUM_SRC; s++) begin
                        if (dec.kind == RG_EN && dec.idx == 16'(s / 32))
                            en_q[c][s] <= bus_wdata[s % 32];
                    end
                end
            end
        end
    end

    // One request gate per real source; source 0 is tied off.
    assign pend[0] = 1'b0;
    assign infl[0] = 1'b0;
    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_gate
        irqc_gateway u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (level_v[s]),
            .claim    (claim_vec[s]),
            .complete (cmpl_vec[s]),
            .pending  (pend[s]),
            .inflight (infl[s])
        );
    end

    // One winner selector and line per context.
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irqc_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .ID_W    (ID_W)
        ) u_arb (
            .elig    (pend & en_q[c]),
            .prio    (prio_q),
            .thresh  (thr_q[c]),
            .best_id (best_id[c])
        );
        assign ctx_irq[c] = (best_id[c] != '0);
    end

    // Claim/complete handshake decode for the addressed context.
    always_comb begin
        claim_go = bus_req && !bus_we && dec.kind == RG_CLAIM;
        cmpl_go  = bus_req && bus_we && dec.kind == RG_CLAIM;
        claim_id = '0;
        en_sel   = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (dec.ctx == 8'(c)) begin
                claim_id = best_id[c];
                en_sel   = en_q[c];
            end
        end
        claim_vec = '0;
        cmpl_vec  = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            claim_vec[s] = claim_go && (claim_id == ID_W'(s));
            cmpl_vec[s]  = cmpl_go && en_sel[s] && (bus_wdata == 32'(s));
        end
    end

    // Read multiplexer; unmapped space yields zero.
    always_comb begin
        rd_val = '0;
        case (dec.kind)
            RG_PRIO: begin
                for (int s = 1; s <= NUM_SRC; s++)
                    if (dec.idx == 16'(s)) rd_val[PRIO_W-1:0] = prio_q[s];
            end
            RG_EN: begin
                for (int c = 0; c < NUM_CTX; c++)
                    for (int s = 1; s <= NUM_SRC; s++)
                        if (dec.ctx == 8'(c) && dec.idx == 16'(s / 32))
                            rd_val[s % 32] = en_q[c][s];
            end
            RG_THR: begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (dec.ctx == 8'(c)) rd_val[PRIO_W-1:0] = thr_q[c];
            end
            RG_CLAIM: rd_val[ID_W-1:0] = claim_id;
            default:  rd_val = '0;
        endcase
    end

    // Registered read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            bus_rdata  <= (bus_req && !bus_we) ? rd_val : '0;
        end
    end
endmodule

// File: rtl/irqc_checker.sv
// Module: protocol and state checks for irqc_top, attached through bind.
// Assumes it sees the top's gate state vectors and claim strobes.
module irqc_checker #(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic                 bus_rvalid,
    input logic [NUM_CTX-1:0]   ctx_irq,
    input logic [NUM_SRC:0]     pend,
    input logic [NUM_SRC:0]     infl,
    input logic [NUM_SRC:0]     claim_vec
);
    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_no_stray_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    assert_line_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_irq != '0) |-> (pend != '0));

    assert_pend_infl_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & infl) == '0);

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
        assert_claim_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
            claim_vec[s] |=> (!pend[s] && infl[s]));
    end
endmodule

bind irqc_top irqc_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_rvalid (bus_rvalid),
    .ctx_irq    (ctx_irq),
    .pend       (pend),
    .infl       (infl),
    .claim_vec  (claim_vec)
);

// File: tb/irqc_top_tb.sv
// Bench: sweeps a 7-source, 2-context build; expected values computed here.
module irqc_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 7;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_level = '0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [23:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] ctx_irq;

    int checks = 0;
    int fails  = 0;
    logic last_rv;

    irqc_top #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3), .ADDR_W(24)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [23:0] a_prio(int n);
        return 24'(4 * n);
    endfunction
    function automatic logic [23:0] a_en(int c, int w);
        return 24'(32'h2000 + c * 32'h80 + 4 * w);
    endfunction
    function automatic logic [23:0] a_thr(int c);
        return 24'(32'h20_0000 + c * 32'h1000);
    endfunction
    function automatic logic [23:0] a_clm(int c);
        return 24'(32'h20_0004 + c * 32'h1000);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [23:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = addr;
        @(negedge clk);
        bus_req = 1'b0;
        data    = bus_rdata;
        last_rv = bus_rvalid;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_level = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_all(input logic [NS-1:0] v);
        @(negedge clk); src_level = v;
        @(negedge clk); src_level = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // R1: reset state
        check("R1 irq", 32'(ctx_irq), 0);
        check("R1 rvalid", 32'(bus_rvalid), 0);
        rd(a_prio(1), d);  check("R1 prio", d, 0);
        rd(a_en(1, 0), d); check("R1 enable", d, 0);
        rd(a_thr(0), d);   check("R1 thr", d, 0);
        rd(a_clm(0), d);   check("R1 claim", d, 0);

        // R11: read response timing
        check("R11 rvalid after read", 32'(last_rv), 1);
        @(negedge clk);
        check("R11 rvalid idle", 32'(bus_rvalid), 0);

        // R2: priority words, width and source 0
        wr(a_prio(0), 32'h7);
        rd(a_prio(0), d); check("R2 src0", d, 0);
        for (int n = 1; n <= NS; n++) wr(a_prio(n), 32'hFFFF_FFF8 | 32'((n * 3) % 8));
        for (int n = 1; n <= NS; n++) begin
            rd(a_prio(n), d); check("R2 prio readback", d, 32'((n * 3) % 8));
        end

        // R3: enable bitmaps per context
        wr(a_en(1, 0), 32'hFFFF_FFFF);
        rd(a_en(1, 0), d); check("R3 ctx1 mask", d, 32'h0000_00FE);
        rd(a_en(0, 0), d); check("R3 ctx0 independent", d, 0);

        // R10: unmapped space
        do_reset();
        wr(24'h00_1000, 32'hFFFF_FFFF);
        wr(a_prio(NS + 1), 32'h7);
        wr(a_thr(NC), 32'h7);
        wr(a_en(0, 1), 32'hFFFF_FFFF);
        wr(24'h20_0008, 32'h7);
        rd(24'h00_1000, d);   check("R10 gap read", d, 0);
        rd(a_prio(NS + 1), d); check("R10 past prio", d, 0);
        rd(a_en(0, 1), d);    check("R10 en word1", d, 0);
        rd(a_thr(NC), d);     check("R10 ctx beyond", d, 0);
        rd(24'h20_0008, d);   check("R10 ctx offset 8", d, 0);
        rd(a_thr(0), d);      check("R10 thr untouched", d, 0);
        rd(a_en(0, 0), d);    check("R10 en untouched", d, 0);
        for (int n = 1; n <= NS; n++) begin
            rd(a_prio(n), d); check("R10 prio untouched", d, 0);
        end

        // R5: every priority/threshold pair on source 1, ctx0
        do_reset();
        wr(a_en(0, 0), 32'h2);
        pulse_all(7'h01);
        for (int p = 0; p < 8; p++) begin
            wr(a_prio(1), 32'(p));
            for (int t = 0; t < 8; t++) begin
                wr(a_thr(0), 32'(t));
                check("R5 line vs threshold", 32'(ctx_irq[0]), 32'(p > t));
                check("R5 other ctx idle", 32'(ctx_irq[1]), 0);
            end
        end
        // R9: still pending although the input dropped long ago
        wr(a_thr(0), 0);
        rd(a_clm(0), d); check("R9 latched request", d, 1);

        // R6: drain order under arithmetic priority patterns
        for (int k = 0; k < 5; k++) begin
            for (int m = 0; m < 3; m++) begin
                logic [NS:1] left;
                do_reset();
                for (int n = 1; n <= NS; n++) wr(a_prio(n), 32'((n * k + m) % 8));
                wr(a_en(0, 0), 32'hFE);
                pulse_all('1);
                left = '1;
                for (int step = 0; step <= NS; step++) begin
                    int bp;
                    int bid;
                    bp = 0; bid = 0;
                    for (int n = 1; n <= NS; n++)
                        if (left[n] && ((n * k + m) % 8) > bp) begin
                            bp = (n * k + m) % 8; bid = n;
                        end
                    check("R5 line before claim", 32'(ctx_irq[0]), 32'(bid != 0));
                    rd(a_clm(0), d); check("R6 claim order", d, 32'(bid));
                    if (bid != 0) begin
                        left[bid] = 1'b0;
                        wr(a_clm(0), 32'(bid));
                    end
                end
            end
        end

        // R7 and R8: gate blocking and completion filtering
        do_reset();
        wr(a_prio(2), 3);
        wr(a_en(0, 0), 32'h4);
        @(negedge clk); src_level = 7'h02;
        repeat (2) @(negedge clk);
        check("R5 held source", 32'(ctx_irq[0]), 1);
        rd(a_clm(0), d); check("R7 claim id", d, 2);
        check("R7 line drops after claim", 32'(ctx_irq[0]), 0);
        repeat (3) @(negedge clk);
        check("R7 level ignored while claimed", 32'(ctx_irq[0]), 0);
        rd(a_clm(0), d); check("R7 second claim empty", d, 0);
        wr(a_clm(0), 3);
        repeat (2) @(negedge clk);
        check("R8 wrong id ignored", 32'(ctx_irq[0]), 0);
        wr(a_clm(1), 2);
        repeat (2) @(negedge clk);
        check("R8 non-enabled ctx ignored", 32'(ctx_irq[0]), 0);
        wr(a_clm(0), 2);
        @(negedge clk);
        check("R8 completion reopens", 32'(ctx_irq[0]), 1);
        src_level = '0;

        // R4: per-context threshold and claim
        do_reset();
        wr(a_prio(1), 5);
        wr(a_en(0, 0), 32'h2);
        wr(a_en(1, 0), 32'h2);
        wr(a_thr(0), 7);
        pulse_all(7'h01);
        check("R4 lines per ctx", 32'(ctx_irq), 32'h2);
        rd(a_thr(0), d); check("R4 thr ctx0", d, 7);
        rd(a_thr(1), d); check("R4 thr ctx1", d, 0);
        rd(a_clm(0), d); check("R4 ctx0 claim", d, 0);
        rd(a_clm(1), d); check("R4 ctx1 claim", d, 1);
        check("R4 lines after claim", 32'(ctx_irq), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule